// File: doc/BRIEF.md
# RV32 Load/Store Unit

This block connects the execute stage of a 32-bit RISC-V core to a data-side memory bus. For each memory operation it receives the kind of access (byte, halfword or word; load or store; signed or unsigned), the effective address, the store data and the destination register. It checks alignment before anything leaves the block. An aligned operation becomes one request on a valid/ready channel. The request carries a word-aligned address, lane-replicated write data and a byte-enable mask.

A store is finished once its request is taken. A load holds the unit busy in a wait state until a valid/ready response arrives. The unit then shifts the addressed byte or halfword down to bit 0 and extends it by sign or by zero for register writeback. A misaligned access raises an exception flag in the same cycle it is offered and never reaches the bus. The core uses `op_ready` and `busy` to stall.

Top module: `rv_lsu`

## Requirements
- R1: While reset is high, and in the first cycle after it, `req_valid`, `rsp_ready`, `wb_valid` and `busy` are 0 and `op_ready` is 1.
- R2: An operation offered while idle is misaligned in two cases: the size is word (`op_size`=2) and address bits [1:0] are not 00, or the size is halfword (`op_size`=1) and address bit 0 is 1. Bytes (`op_size`=0) are never misaligned. A misaligned operation raises `misalign_exc` combinationally in that cycle, with `misalign_store` equal to `op_is_store`. It issues no request, and the unit stays idle.
- R3: An aligned operation accepted while idle gives `req_valid`=1 from the next cycle. `req_addr` holds the address with bits [1:0] cleared, and `req_we` equals the store flag. All request fields hold steady until the cycle in which `req_ready` is high.
- R4: `req_strb` bit i enables byte lane i (bits 8i+7..8i). The mask is 0001 shifted left by the offset for a byte, 0011 shifted left by the offset for a halfword, and 1111 for a word.
- R5: Store data is placed on every lane. A byte is copied into all four lanes, a halfword into both halves, and a word is sent unchanged. Loads send zero write data.
- R6: A store returns to idle once its request is accepted. It never raises `wb_valid`.
- R7: After a load's request is accepted, the unit holds `busy`=1 and `rsp_ready`=1 until `rsp_valid` is seen. `wb_valid` is high only in the cycle where `rsp_valid` and `rsp_ready` are both high, and the unit is idle on the next cycle.
- R8: Load result: the addressed lane(s) are first shifted down to bit 0 and then extended. Signed byte and halfword loads (`op_unsigned`=0) extend by sign, and unsigned ones extend by zero. For example, byte 0x80 gives 0xFFFFFF80 signed and 0x00000080 unsigned. A word is returned unchanged.
- R9: The size, signedness, address offset and destination register are captured when the operation is accepted. Changes on the operation inputs while the unit is busy do not alter `wb_data` or `wb_rd`.
- R10: `req_amo` is always zero.
- R11: An operation is taken only while idle. While busy, `op_ready` is 0, `misalign_exc` stays 0, and an offered operation produces no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Memory operation offered |
| op_is_store | input | 1 | 1 = store, 0 = load |
| op_size | input | 2 | 0 byte, 1 halfword, 2 word (3 treated as word) |
| op_unsigned | input | 1 | Zero-extend load result |
| op_addr | input | AW | Effective address |
| op_wdata | input | 32 | Store data, right-aligned |
| op_rd | input | RD_W | Destination register of a load |
| op_ready | output | 1 | Unit idle, operation may be taken |
| busy | output | 1 | Operation in flight, core must stall |
| misalign_exc | output | 1 | Misaligned-access exception |
| misalign_store | output | 1 | Exception belongs to a store |
| req_valid | output | 1 | Bus request valid |
| req_ready | input | 1 | Bus request taken |
| req_addr | output | AW | Word-aligned request address |
| req_we | output | 1 | Request is a write |
| req_wdata | output | 32 | Lane-replicated write data |
| req_strb | output | 4 | Byte-lane enables |
| req_amo | output | AMO_W | Atomic-operation code, held inactive |
| rsp_valid | input | 1 | Bus response valid |
| rsp_ready | output | 1 | Unit waiting for response |
| rsp_rdata | input | 32 | Response word |
| wb_valid | output | 1 | Load result valid for writeback |
| wb_rd | output | RD_W | Destination register |
| wb_data | output | 32 | Extended load result |

## Verification
The sweep runs every size, signedness, direction and byte offset, with response words whose lanes alternate their top bit. This catches a design that extends before it shifts, which would return the sign of byte 0 for offsets 1 to 3. Halfword offsets 1 and 3 and all non-zero word offsets must raise the exception and leave the bus silent. A design that let them through would show `req_valid` on the next cycle. Ready and response delays vary, so a design that wrote back early, or dropped `req_valid` before `req_ready`, breaks the stability and timing checks. During each wait the bench also scrambles the operation inputs and offers a fresh store, which exposes formatting from live inputs and a second request issued while busy.

// File: rtl/rv_lsu_pkg.sv
package rv_lsu_pkg;

    localparam int XLEN  = 32;
    localparam int NLANE = XLEN / 8;
    localparam int OFF_W = $clog2(NLANE);

    typedef enum logic [1:0] {
        MSZ_BYTE = 2'd0,
        MSZ_HALF = 2'd1,
        MSZ_WORD = 2'd2,
        MSZ_RSVD = 2'd3
    } msize_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } lsu_state_e;

    // attributes kept while an access is outstanding
    typedef struct packed {
        logic                 is_store;
        msize_e               size;
        logic                 zext;
        logic [OFF_W-1:0]     off;
    } pend_t;

    function automatic logic is_misaligned(msize_e sz, logic [OFF_W-1:0] off);
        case (sz)
            MSZ_BYTE: return 1'b0;
            MSZ_HALF: return off[0];
            default:  return off != '0;
        endcase
    endfunction

endpackage

// File: rtl/lsu_req_shape.sv
module lsu_req_shape
    import rv_lsu_pkg::*;
(
    input  msize_e             size_i,
    input  logic [OFF_W-1:0]   off_i,
    input  logic [XLEN-1:0]    wdata_i,
    output logic               misal_o,
    output logic [NLANE-1:0]   strb_o,
    output logic [XLEN-1:0]    lane_data_o
);

    assign misal_o = is_misaligned(size_i, off_i);

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        localparam logic [OFF_W-1:0] LIDX = OFF_W'(l);
        localparam int HSEL = (l % 2) * 8;

        always_comb begin
            case (size_i)
                MSZ_BYTE: begin
                    strb_o[l]             = (off_i == LIDX);
                    lane_data_o[l*8 +: 8] = wdata_i[7:0];
                end
                MSZ_HALF: begin
                    strb_o[l]             = (off_i[OFF_W-1:1] == LIDX[OFF_W-1:1]);
                    lane_data_o[l*8 +: 8] = wdata_i[HSEL +: 8];
                end
                default: begin
                    strb_o[l]             = 1'b1;
                    lane_data_o[l*8 +: 8] = wdata_i[l*8 +: 8];
                end
            endcase
        end
    end

endmodule

// File: rtl/lsu_load_fmt.sv
module lsu_load_fmt
    import rv_lsu_pkg::*;
(
    input  logic [XLEN-1:0]    rdata_i,
    input  msize_e             size_i,
    input  logic               zext_i,
    input  logic [OFF_W-1:0]   off_i,
    output logic [XLEN-1:0]    result_o
);

    logic [7:0]  lanes [NLANE];
    logic [7:0]  byte_v;
    logic [15:0] half_v;

    for (genvar l = 0; l < NLANE; l++) begin : g_split
        assign lanes[l] = rdata_i[l*8 +: 8];
    end

    // lane selection first, extension afterwards
    assign byte_v = lanes[off_i];
    assign half_v = {lanes[{off_i[OFF_W-1:1], 1'b1}], lanes[{off_i[OFF_W-1:1], 1'b0}]};

    always_comb begin
        case (size_i)
            MSZ_BYTE: result_o = zext_i ? {{(XLEN-8){1'b0}}, byte_v}
                                        : {{(XLEN-8){byte_v[7]}}, byte_v};
            MSZ_HALF: result_o = zext_i ? {{(XLEN-16){1'b0}}, half_v}
                                        : {{(XLEN-16){half_v[15]}}, half_v};
            default:  result_o = rdata_i;
        endcase
    end

endmodule

// File: rtl/rv_lsu.sv
module rv_lsu
    import rv_lsu_pkg::*;
#(
    parameter int AW    = 32,
    parameter int RD_W  = 5,
    parameter int AMO_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               op_valid,
    input  logic               op_is_store,
    input  logic [1:0]         op_size,
    input  logic               op_unsigned,
    input  logic [AW-1:0]      op_addr,
    input  logic [XLEN-1:0]    op_wdata,
    input  logic [RD_W-1:0]    op_rd,
    output logic               op_ready,
    output logic               busy,
    output logic               misalign_exc,
    output logic               misalign_store,
    output logic               req_valid,
    input  logic               req_ready,
    output logic [AW-1:0]      req_addr,
    output logic               req_we,
    output logic [XLEN-1:0]    req_wdata,
    output logic [NLANE-1:0]   req_strb,
    output logic [AMO_W-1:0]   req_amo,
    input  logic               rsp_valid,
    output logic               rsp_ready,
    input  logic [XLEN-1:0]    rsp_rdata,
    output logic               wb_valid,
    output logic [RD_W-1:0]    wb_rd,
    output logic [XLEN-1:0]    wb_data
);

    lsu_state_e           state_q;
    pend_t                pend_q;
    logic [RD_W-1:0]      rd_q;
    logic [AW-1:0]        addr_q;
    logic [XLEN-1:0]      wdata_q;
    logic [NLANE-1:0]     strb_q;

    msize_e               in_size;
    logic [OFF_W-1:0]     in_off;
    logic                 shape_misal;
    logic [NLANE-1:0]     shape_strb;
    logic [XLEN-1:0]      shape_data;
    logic                 idle;
    logic                 take;

    assign in_size = msize_e'(op_size);
    assign in_off  = op_addr[OFF_W-1:0];

    lsu_req_shape u_shape (
        .size_i      (in_size),
        .off_i       (in_off),
        .wdata_i     (op_wdata),
        .misal_o     (shape_misal),
        .strb_o      (shape_strb),
        .lane_data_o (shape_data)
    );

    assign idle           = (state_q == ST_IDLE);
    assign take           = idle && op_valid && !shape_misal;
    assign misalign_exc   = idle && op_valid && shape_misal;
    assign misalign_store = op_is_store;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            rd_q    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            strb_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (take) begin
                        state_q         <= ST_REQ;
                        pend_q.is_store <= op_is_store;
                        pend_q.size     <= in_size;
                        pend_q.zext     <= op_unsigned;
                        pend_q.off      <= in_off;
                        rd_q            <= op_rd;
                        addr_q          <= {op_addr[AW-1:OFF_W], {OFF_W{1'b0}}};
                        wdata_q         <= op_is_store ? shape_data : '0;
                        strb_q          <= shape_strb;
                    end
                end
                ST_REQ: begin
                    if (req_ready) begin
                        state_q <= pend_q.is_store ? ST_IDLE : ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (rsp_valid) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign op_ready  = idle;
    assign busy      = !idle;
    assign req_valid = (state_q == ST_REQ);
    assign req_addr  = addr_q;
    assign req_we    = pend_q.is_store;
    assign req_wdata = wdata_q;
    assign req_strb  = strb_q;
    assign req_amo   = '0;
    assign rsp_ready = (state_q == ST_WAIT);
    assign wb_valid  = (state_q == ST_WAIT) && rsp_valid;
    assign wb_rd     = rd_q;

    lsu_load_fmt u_fmt (
        .rdata_i  (rsp_rdata),
        .size_i   (pend_q.size),
        .zext_i   (pend_q.zext),
        .off_i    (pend_q.off),
        .result_o (wb_data)
    );

    // R2: an exception cycle is never followed by a bus request
    p_misal_no_req_r2: assert property (@(posedge clk) disable iff (rst)
        misalign_exc |=> !req_valid);

    // R3: request payload held until taken
    p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)
            && $stable(req_strb) && $stable(req_wdata) && $stable(req_we)));

    // R4: mask covers one, two or four lanes
    p_strb_count_r4: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> ($countones(req_strb) == 1 || $countones(req_strb) == 2
            || $countones(req_strb) == 4));

    // R6: a taken store frees the unit with no writeback
    p_store_done_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_we) |=> (!busy && !wb_valid));

    // R7: writeback only on a response handshake
    p_wb_on_rsp_r7: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> (rsp_valid && rsp_ready && !req_we));

    // R11: no exception flagged while an access is in flight
    p_busy_no_exc_r11: assert property (@(posedge clk) disable iff (rst)
        busy |-> !misalign_exc);

endmodule

// File: tb/rv_lsu_bench.sv
`timescale 1ns/100ps
module rv_lsu_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic        op_is_store = 1'b0;
    logic [1:0]  op_size = 2'd0;
    logic        op_unsigned = 1'b0;
    logic [31:0] op_addr = '0;
    logic [31:0] op_wdata = '0;
    logic [4:0]  op_rd = '0;
    logic        op_ready, busy, misalign_exc, misalign_store;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [31:0] req_addr;
    logic        req_we;
    logic [31:0] req_wdata;
    logic [3:0]  req_strb;
    logic [4:0]  req_amo;
    logic        rsp_valid = 1'b0;
    logic        rsp_ready;
    logic [31:0] rsp_rdata = '0;
    logic        wb_valid;
    logic [4:0]  wb_rd;
    logic [31:0] wb_data;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    rv_lsu u_rv_lsu (
        .clk(clk), .rst(rst),
        .op_valid(op_valid), .op_is_store(op_is_store), .op_size(op_size),
        .op_unsigned(op_unsigned), .op_addr(op_addr), .op_wdata(op_wdata),
        .op_rd(op_rd), .op_ready(op_ready), .busy(busy),
        .misalign_exc(misalign_exc), .misalign_store(misalign_store),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_we(req_we), .req_wdata(req_wdata), .req_strb(req_strb),
        .req_amo(req_amo), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_rdata(rsp_rdata), .wb_valid(wb_valid), .wb_rd(wb_rd),
        .wb_data(wb_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: handshake timeout actual=%0d expected<=100000", cyc);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    function automatic logic exp_mis(int sz, int off);
        if (sz == 0) return 1'b0;
        if (sz == 1) return (off % 2) != 0;
        return off != 0;
    endfunction

    function automatic logic [3:0] exp_strb(int sz, int off);
        if (sz == 0) return 4'(1 << off);
        if (sz == 1) return 4'(3 << off);
        return 4'hF;
    endfunction

    function automatic logic [31:0] exp_wd(int sz, logic [31:0] w);
        if (sz == 0) return {4{w[7:0]}};
        if (sz == 1) return {2{w[15:0]}};
        return w;
    endfunction

    function automatic logic [31:0] exp_ld(logic [31:0] d, int sz, logic uns, int off);
        logic [31:0] sh;
        sh = d >> (8 * off);
        if (sz == 0) return uns ? (sh & 32'hFF) : 32'(signed'(sh[7:0]));
        if (sz == 1) return uns ? (sh & 32'hFFFF) : 32'(signed'(sh[15:0]));
        return d;
    endfunction

    task automatic do_op(input logic st, input int sz, input logic uns, input int off,
                         input logic [31:0] wd, input logic [31:0] rdat,
                         input logic [4:0] rd, input int rq_lat, input int rs_lat);
        logic [31:0] base;
        base = 32'h8000_0100 + 32'(rd) * 4;
        @(negedge clk);
        op_valid    = 1'b1;
        op_is_store = st;
        op_size     = 2'(sz);
        op_unsigned = uns;
        op_addr     = base + 32'(off);
        op_wdata    = wd;
        op_rd       = rd;
        #0.5;
        check("R2 misalign_exc", 32'(misalign_exc), 32'(exp_mis(sz, off)));
        if (exp_mis(sz, off)) begin
            check("R2 misalign_store", 32'(misalign_store), 32'(st));
            @(negedge clk);
            op_valid = 1'b0;
            check("R2 no request after misaligned op", 32'(req_valid), 32'd0);
            check("R2 still idle", 32'(op_ready), 32'd1);
            return;
        end
        check("R11 op_ready when idle", 32'(op_ready), 32'd1);
        @(negedge clk);
        op_valid    = 1'b0;
        // R9: scramble inputs while busy
        op_size     = 2'((sz + 1) % 3);
        op_unsigned = ~uns;
        op_addr     = 32'h0000_0003;
        op_rd       = ~rd;
        op_wdata    = ~wd;
        check("R3 req_valid", 32'(req_valid), 32'd1);
        check("R3 req_addr", req_addr, base);
        check("R3 req_we", 32'(req_we), 32'(st));
        check("R4 req_strb", 32'(req_strb), 32'(exp_strb(sz, off)));
        check("R5 req_wdata", req_wdata, st ? exp_wd(sz, wd) : 32'h0);
        check("R10 req_amo", 32'(req_amo), 32'd0);
        for (int i = 0; i < rq_lat; i++) begin
            @(negedge clk);
            check("R3 req held", 32'(req_valid), 32'd1);
            check("R3 addr held", req_addr, base);
            check("R3 strb held", 32'(req_strb), 32'(exp_strb(sz, off)));
        end
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        if (st) begin
            check("R6 store idle", 32'(op_ready), 32'd1);
            check("R6 store no wb", 32'(wb_valid), 32'd0);
            return;
        end
        check("R7 busy in wait", 32'(busy), 32'd1);
        check("R7 rsp_ready", 32'(rsp_ready), 32'd1);
        check("R7 no early wb", 32'(wb_valid), 32'd0);
        // R11: offer a store while busy
        op_valid    = 1'b1;
        op_is_store = 1'b1;
        op_size     = 2'd2;
        op_addr     = 32'h8000_0040;
        #0.5;
        check("R11 op_ready low while busy", 32'(op_ready), 32'd0);
        check("R11 no exception while busy", 32'(misalign_exc), 32'd0);
        for (int i = 0; i < rs_lat; i++) begin
            @(negedge clk);
            check("R11 no second request", 32'(req_valid), 32'd0);
            check("R7 wait holds", 32'(busy), 32'd1);
            check("R7 no wb before rsp", 32'(wb_valid), 32'd0);
        end
        op_valid  = 1'b0;
        rsp_valid = 1'b1;
        rsp_rdata = rdat;
        #0.5;
        check("R7 wb_valid on rsp", 32'(wb_valid), 32'd1);
        check("R9 wb_rd captured", 32'(wb_rd), 32'(rd));
        check("R8 wb_data", wb_data, exp_ld(rdat, sz, uns, off));
        @(negedge clk);
        rsp_valid = 1'b0;
        #0.5;
        check("R7 idle after rsp", 32'(op_ready), 32'd1);
        check("R7 wb dropped", 32'(wb_valid), 32'd0);
        check("R11 no stray request", 32'(req_valid), 32'd0);
    endtask

    initial begin
        int k;
        k = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 req_valid in reset", 32'(req_valid), 32'd0);
        check("R1 rsp_ready in reset", 32'(rsp_ready), 32'd0);
        check("R1 wb_valid in reset", 32'(wb_valid), 32'd0);
        check("R1 op_ready in reset", 32'(op_ready), 32'd1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy after reset", 32'(busy), 32'd0);
        check("R1 req_valid after reset", 32'(req_valid), 32'd0);
        for (int p = 0; p < 2; p++) begin
            for (int st = 0; st < 2; st++) begin
                for (int sz = 0; sz < 3; sz++) begin
                    for (int u = 0; u < 2; u++) begin
                        for (int off = 0; off < 4; off++) begin
                            do_op(1'(st), sz, 1'(u), off,
                                  p == 0 ? 32'hA1B2_C3D4 : 32'h5E6F_7081,
                                  p == 0 ? 32'h807F_FF01 : 32'h7F80_01FE,
                                  5'(k), (off + p) % 3, (sz + off) % 3);
                            k++;
                        end
                    end
                end
            end
        end
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule